// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address from an embedded scalar processor into a physical address. Each virtual address has three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset inside a 4 KiB page.

The block first looks the page up in a small cache of recent translations. On a miss it reads one entry from each of the two tables in system memory. Table reads go through a read port with a valid/ready request and a one-cycle response strobe. The walk starts at the first-level table, whose page frame number software writes into a base register. Software owns the tables. The block only reads them and never writes them.

Every table entry is 32 bits wide. Bit 0 is the valid flag. Bits 31:12 give the frame of the next-level table, or of the data page. After software unmaps or frees a page, it must pulse the invalidate input so that later lookups re-read the tables.

Top module: `vat_top`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and no cached translation exists.
- R2: A miss makes two table reads. The first is at address {base frame, va[31:22], 2'b00}. The second is at address {first entry[31:12], va[21:12], 2'b00}. The response has `rsp_fault`=0 and `rsp_paddr`={second entry[31:12], va[11:0]}. A read request holds its valid and its address until it is accepted.
- R3: If bit 0 of the first-level entry is 0, the block returns a fault after one read. It makes no second read and caches nothing, so a repeat of the request walks again.
- R4: If bit 0 of the second-level entry is 0, the block returns a fault after two reads and caches nothing.
- R5: An access to a page that is already cached raises `rsp_valid` in the cycle after the request is accepted. It returns the same physical address as the walk did and makes no memory read.
- R6: A pulse on `tlb_inv` while no walk is running removes every cached translation at that clock edge.
- R7: Writing the base register does not disturb cached translations. Walks started after the write use the new base.
- R8: The cache holds 8 translations and replaces them in round-robin order. The ninth distinct fill evicts the oldest fill, and hits do not change the replacement order.
- R9: A pulse on `tlb_inv` during a walk lets that walk finish and return its correct result. The result is not cached. Every cached translation is removed when the walk ends.
- R10: Only one request is in flight. `req_ready` is 0 while a walk is running and in any cycle in which `tlb_inv` is 1.
- R11: Each accepted request gets exactly one response cycle. A fault response carries `rsp_paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle per request |
| rsp_fault | output | 1 | Walk hit an entry with bit 0 clear |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table entry read from memory |
| base_wr | input | 1 | Write strobe for the base register |
| base_pfn_in | input | 20 | Frame number of the first-level table |
| tlb_inv | input | 1 | Invalidate all cached translations |

## Verification
A cached hit is due exactly one cycle after the accepting edge. The bench checks this by counting falling edges from acceptance until `rsp_valid` is seen, and it requires the count to be 1. A walk takes a variable number of cycles, because the memory model changes its stall and its latency from one read to the next. For walks, the bench therefore waits on `rsp_valid` with a bound and checks the number of reads and their addresses, not a fixed cycle count. All outputs are sampled on the falling edge. One further falling edge is checked to confirm that no second response follows.

// File: rtl/vat_pkg.sv
// Shared definitions for the address translator.
// Assumes a table entry carries its valid flag in bit 0.
package vat_pkg;
    typedef enum logic [2:0] {
        WK_IDLE,
        WK_L1_REQ,
        WK_L1_WAIT,
        WK_L2_REQ,
        WK_L2_WAIT
    } wk_state_t;

    localparam int ENTRY_VALID_BIT = 0;
endpackage

// File: rtl/vat_tlb.sv
// Fully associative translation cache with round-robin replacement.
// Lookup is combinational. A fill and a flush take effect at the clock edge.
// Assumes the caller never fills a page number that is already present.
module vat_tlb #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush,
    output logic [DEPTH-1:0] vld_o
);
    logic [DEPTH-1:0] vld_q;
    logic [VPN_W-1:0] tag_q [DEPTH];
    logic [PFN_W-1:0] pfn_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [DEPTH-1:0] match;

    // One tag comparator for each slot.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
        end
    endgenerate

    // OR together the frame of the (at most one) matching slot.
    always_comb begin
        lk_pfn = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match[k]) lk_pfn = lk_pfn | pfn_q[k];
        end
    end

    assign lk_hit = |match;
    assign vld_o  = vld_q;

    // Valid bits and the replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Tag and frame storage. No reset is needed, because vld_q gates it.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[ptr_q] <= fill_vpn;
            pfn_q[ptr_q] <= fill_pfn;
        end
    end
endmodule

// File: rtl/vat_walker.sv
// Two-level table walk sequencer.
// It captures the base frame when a walk starts, reads the first-level entry,
// then reads the second-level entry. An entry with bit 0 clear ends the walk.
// Assumes walk_vpn stays stable from the cycle after start until done.
module vat_walker
    import vat_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = OFF_W - 2,
    localparam int PFN_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PFN_W-1:0]   base_pfn,
    input  logic [2*IDX_W-1:0] walk_vpn,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic               done,
    output logic               done_fault,
    output logic [PFN_W-1:0]   done_pfn
);
    wk_state_t        state_q;
    logic [PFN_W-1:0] tbl_pfn_q;
    logic [IDX_W-1:0] idx;
    logic             entry_ok;
    logic             unused_bits;

    assign entry_ok    = mem_rsp_data[ENTRY_VALID_BIT];
    assign unused_bits = ^mem_rsp_data[OFF_W-1:1];

    // Step through the request and wait states of both levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
        end else begin
            case (state_q)
                WK_IDLE:    if (start)         state_q <= WK_L1_REQ;
                WK_L1_REQ:  if (mem_req_ready) state_q <= WK_L1_WAIT;
                WK_L1_WAIT: if (mem_rsp_valid) state_q <= entry_ok ? WK_L2_REQ : WK_IDLE;
                WK_L2_REQ:  if (mem_req_ready) state_q <= WK_L2_WAIT;
                WK_L2_WAIT: if (mem_rsp_valid) state_q <= WK_IDLE;
                default:                       state_q <= WK_IDLE;
            endcase
        end
    end

    // Frame of the table that is read next: the base at start, then the level-1 result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_pfn_q <= '0;
        end else if (state_q == WK_IDLE && start) begin
            tbl_pfn_q <= base_pfn;
        end else if (state_q == WK_L1_WAIT && mem_rsp_valid) begin
            tbl_pfn_q <= mem_rsp_data[PA_W-1:OFF_W];
        end
    end

    // Form the entry address from the table frame and the index of this level.
    always_comb begin
        idx           = (state_q == WK_L1_REQ) ? walk_vpn[2*IDX_W-1:IDX_W] : walk_vpn[IDX_W-1:0];
        mem_req_valid = (state_q == WK_L1_REQ) || (state_q == WK_L2_REQ);
        mem_req_addr  = {tbl_pfn_q, idx, 2'b00};
    end

    assign busy       = (state_q != WK_IDLE);
    assign done       = mem_rsp_valid &&
                        ((state_q == WK_L1_WAIT && !entry_ok) || state_q == WK_L2_WAIT);
    assign done_fault = !entry_ok;
    assign done_pfn   = mem_rsp_data[PA_W-1:OFF_W];
endmodule

// File: rtl/vat_top.sv
// Virtual-to-physical address translator. It holds the base register, the
// translation cache, the walk sequencer and the response register.
// Assumes one request in flight. An invalidate that arrives during a walk is
// held back until the walk ends, and that walk's result is then not cached.
module vat_top #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int TLB_N = 8,
    localparam int IDX_W = OFF_W - 2,
    localparam int VPN_W = 2 * IDX_W,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PFN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data,
    input  logic             base_wr,
    input  logic [PFN_W-1:0] base_pfn_in,
    input  logic             tlb_inv
);
    logic [PFN_W-1:0] base_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             inv_pend_q;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [TLB_N-1:0] tlb_vld;
    logic             wk_busy, wk_done, wk_fault;
    logic [PFN_W-1:0] wk_pfn;
    logic             accept, start_walk, flush, fill;
    logic             rsp_valid_q, rsp_fault_q;
    logic [PA_W-1:0]  rsp_paddr_q;

    assign req_ready  = !wk_busy && !tlb_inv;
    assign accept     = req_valid && req_ready;
    assign start_walk = accept && !lk_hit;
    assign flush      = (tlb_inv && !wk_busy) || (wk_done && (inv_pend_q || tlb_inv));
    assign fill       = wk_done && !wk_fault && !inv_pend_q && !tlb_inv;

    // Level-1 table base register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= base_pfn_in;
    end

    // Hold the page number and offset of the request that is being walked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            off_q <= '0;
        end else if (start_walk) begin
            vpn_q <= req_vaddr[VA_W-1:OFF_W];
            off_q <= req_vaddr[OFF_W-1:0];
        end
    end

    // Remember an invalidate that arrived mid-walk until the walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                  inv_pend_q <= 1'b0;
        else if (wk_done)            inv_pend_q <= 1'b0;
        else if (wk_busy && tlb_inv) inv_pend_q <= 1'b1;
    end

    vat_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .DEPTH(TLB_N)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit   (lk_hit),
        .lk_pfn   (lk_pfn),
        .fill_en  (fill),
        .fill_vpn (vpn_q),
        .fill_pfn (wk_pfn),
        .flush    (flush),
        .vld_o    (tlb_vld)
    );

    vat_walker #(.PA_W(PA_W), .OFF_W(OFF_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_walk),
        .base_pfn      (base_q),
        .walk_vpn      (vpn_q),
        .busy          (wk_busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (wk_done),
        .done_fault    (wk_fault),
        .done_pfn      (wk_pfn)
    );

    // Register the response from a cache hit or from the end of a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_paddr_q <= '0;
        end else begin
            rsp_valid_q <= (accept && lk_hit) || wk_done;
            if (accept && lk_hit) begin
                rsp_fault_q <= 1'b0;
                rsp_paddr_q <= {lk_pfn, req_vaddr[OFF_W-1:0]};
            end else if (wk_done) begin
                rsp_fault_q <= wk_fault;
                rsp_paddr_q <= wk_fault ? '0 : {wk_pfn, off_q};
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_fault = rsp_fault_q;
    assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/vat_chk.sv
// Protocol and timing checks for vat_top, attached through bind.
// Assumes it is bound inside vat_top so that cache-internal signals are visible.
module vat_chk #(
    parameter int PA_W  = 32,
    parameter int TLB_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             tlb_hit,
    input logic             tlb_flush,
    input logic [TLB_N-1:0] tlb_vld
);
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tlb_hit) |=> rsp_valid); // R5

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid))); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |=> (tlb_vld == '0)); // R6
endmodule

bind vat_top vat_chk #(.PA_W(PA_W), .TLB_N(TLB_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .tlb_hit       (lk_hit),
    .tlb_flush     (flush),
    .tlb_vld       (tlb_vld)
);

// File: tb/vat_top_test.sv
`timescale 1ns/1ps
// Self-checking bench for vat_top. The memory model computes its table
// entries arithmetically, and the expected translations come from those same formulas.
module vat_top_test;
    localparam logic [19:0] BASE_A = 20'h00010;
    localparam logic [19:0] BASE_B = 20'h00020;
    localparam int L2A = 'h1000;
    localparam int L2B = 'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        base_wr = 1'b0;
    logic [19:0] base_pfn_in = '0;
    logic        tlb_inv = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int m_reads;
    int cyc;
    logic        m_pend;
    int          m_cnt;
    logic [31:0] m_addr, last_addr, prev_addr;

    always #2.5 clk = ~clk;

    vat_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .base_wr(base_wr),
        .base_pfn_in(base_pfn_in), .tlb_inv(tlb_inv)
    );

    // Table contents as a function of the byte address.
    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        int p, ix;
        p  = int'(a[31:12]);
        ix = int'(a[11:2]);
        if (p == int'(BASE_A)) return {20'(L2A + ix), 11'd0, (ix % 3) != 2};
        if (p == int'(BASE_B)) return {20'(L2B + ix), 11'd0, (ix % 4) != 3};
        if (p >= L2A && p < L2A + 1024)
            return {20'((p - L2A) * 7 + ix * 13 + 'h30000), 11'd0, (ix % 5) != 4};
        if (p >= L2B && p < L2B + 1024)
            return {20'((p - L2B) * 11 + ix * 3 + 'h50000), 11'd0, (ix % 7) != 6};
        return 32'd0;
    endfunction

    // Expected {fault, paddr} for a virtual address under a given base.
    function automatic logic [32:0] ref_xl(input logic [31:0] va, input logic [19:0] base);
        logic [31:0] e1, e2;
        e1 = mem_rd({base, va[31:22], 2'b00});
        if (!e1[0]) return {1'b1, 32'd0};
        e2 = mem_rd({e1[31:12], va[21:12], 2'b00});
        if (!e2[0]) return {1'b1, 32'd0};
        return {1'b0, e2[31:12], va[11:0]};
    endfunction

    // Memory responder: a stall pattern on ready and a latency of 0 to 2 cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend        <= 1'b0;
            m_cnt         <= 0;
            m_addr        <= '0;
            m_reads       <= 0;
            cyc           <= 0;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            last_addr     <= '0;
            prev_addr     <= '0;
        end else begin
            cyc           <= cyc + 1;
            mem_rsp_valid <= 1'b0;
            if (m_pend) begin
                if (m_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem_rd(m_addr);
                    m_pend        <= 1'b0;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end else if (mem_req_valid && mem_req_ready) begin
                m_pend    <= 1'b1;
                m_addr    <= mem_req_addr;
                m_cnt     <= m_reads % 3;
                m_reads   <= m_reads + 1;
                prev_addr <= last_addr;
                last_addr <= mem_req_addr;
            end
            mem_req_ready <= (cyc % 4) != 2;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for its response. inv_at >= 1 pulses tlb_inv at that cycle count.
    task automatic xlate(input logic [31:0] va, input int inv_at,
                         output logic f, output logic [31:0] pa, output int lat,
                         output int nrd, output logic rdy_mid, output logic extra);
        int r0;
        @(negedge clk);
        r0 = m_reads;
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_mid = req_ready;
        while (!rsp_valid && lat < 300) begin
            tlb_inv = (lat == inv_at);
            @(negedge clk);
            lat++;
        end
        tlb_inv = 1'b0;
        f   = rsp_fault;
        pa  = rsp_paddr;
        nrd = m_reads - r0;
        @(negedge clk);
        extra = rsp_valid;
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        tlb_inv = 1'b1;
        #1;
        check("R10 ready low during inv", 64'(req_ready), 64'd0);
        @(negedge clk);
        tlb_inv = 1'b0;
    endtask

    task automatic write_base(input logic [19:0] b);
        @(negedge clk);
        base_wr = 1'b1;
        base_pfn_in = b;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    logic        f, rm, ex;
    logic [31:0] pa, pa_a;
    logic [32:0] e;
    int          lat, nrd;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        write_base(BASE_A);

        // Sweep over first-level indices with varied second-level indices and offsets.
        for (int i = 0; i < 48; i++) begin
            logic [31:0] va;
            logic l1bad;
            va = {10'(i), 10'((i * 37 + 3) % 1024), 12'((i * 91) % 4096)};
            e  = ref_xl(va, BASE_A);
            l1bad = (i % 3) == 2;
            xlate(va, -1, f, pa, lat, nrd, rm, ex);
            check("R2 fault flag", 64'(f), 64'(e[32]));
            check("R11 paddr (0 on fault)", 64'(pa), 64'(e[31:0]));
            check("R11 single response", 64'(ex), 64'd0);
            check("R10 ready low in walk", 64'(rm), 64'd0);
            if (l1bad) begin
                check("R3 one read on bad L1", 64'(nrd), 64'd1);
            end else begin
                check("R2 two reads", 64'(nrd), 64'd2);
                check("R2 L1 addr", 64'(prev_addr), 64'({BASE_A, va[31:22], 2'b00}));
                check("R2 L2 addr", 64'(last_addr), 64'({20'(L2A + i), va[21:12], 2'b00}));
            end
            xlate(va, -1, f, pa, lat, nrd, rm, ex);
            if (e[32]) begin
                check(l1bad ? "R3 fault not cached" : "R4 fault not cached",
                      64'(nrd), l1bad ? 64'd1 : 64'd2);
                check("R4 repeat fault", 64'(f), 64'd1);
            end else begin
                check("R5 hit latency", 64'(lat), 64'd1);
                check("R5 hit no reads", 64'(nrd), 64'd0);
                check("R5 hit paddr", 64'(pa), 64'(e[31:0]));
            end
        end

        // R6: an idle invalidate forces a re-walk.
        xlate(32'h0040_1234, -1, f, pa, lat, nrd, rm, ex);
        xlate(32'h0040_1234, -1, f, pa, lat, nrd, rm, ex);
        check("R6 cached before inv", 64'(nrd), 64'd0);
        pulse_inv();
        xlate(32'h0040_1234, -1, f, pa, lat, nrd, rm, ex);
        check("R6 re-walk after inv", 64'(nrd), 64'd2);

        // R8: nine distinct fills, then check which entry was evicted.
        pulse_inv();
        begin
            int l1s [9] = '{0, 1, 3, 4, 6, 7, 9, 10, 12};
            for (int k = 0; k < 9; k++)
                xlate({10'(l1s[k]), 10'd0, 12'h0}, -1, f, pa, lat, nrd, rm, ex);
            for (int k = 1; k < 9; k++) begin
                xlate({10'(l1s[k]), 10'd0, 12'h8}, -1, f, pa, lat, nrd, rm, ex);
                check("R8 survivor hits", 64'(nrd), 64'd0);
            end
            xlate({10'(l1s[0]), 10'd0, 12'h0}, -1, f, pa, lat, nrd, rm, ex);
            check("R8 oldest evicted", 64'(nrd), 64'd2);
            xlate({10'(l1s[1]), 10'd0, 12'h0}, -1, f, pa, lat, nrd, rm, ex);
            check("R8 next oldest evicted", 64'(nrd), 64'd2);
        end

        // R7: a base write keeps cached entries. New walks use the new table.
        pulse_inv();
        xlate(32'h0040_1010, -1, f, pa_a, lat, nrd, rm, ex);
        write_base(BASE_B);
        xlate(32'h0040_1010, -1, f, pa, lat, nrd, rm, ex);
        check("R7 cached kept no reads", 64'(nrd), 64'd0);
        check("R7 cached kept paddr", 64'(pa), 64'(ref_xl(32'h0040_1010, BASE_A)));
        e = ref_xl(32'h0140_2020, BASE_B);
        xlate(32'h0140_2020, -1, f, pa, lat, nrd, rm, ex);
        check("R7 new base walk", 64'({f, pa}), 64'(e));
        pulse_inv();
        xlate(32'h0040_1010, -1, f, pa, lat, nrd, rm, ex);
        check("R7 after inv uses new base", 64'({f, pa}), 64'(ref_xl(32'h0040_1010, BASE_B)));

        // R9: an invalidate during a walk.
        pulse_inv();
        xlate(32'h0000_0000, -1, f, pa, lat, nrd, rm, ex);
        e = ref_xl(32'h0080_9044, BASE_B);
        xlate(32'h0080_9044, 1, f, pa, lat, nrd, rm, ex);
        check("R9 walk result correct", 64'({f, pa}), 64'(e));
        xlate(32'h0080_9044, -1, f, pa, lat, nrd, rm, ex);
        check("R9 result not cached", 64'(nrd), 64'd2);
        check("R9 repeat result", 64'({f, pa}), 64'(e));
        xlate(32'h0000_0000, -1, f, pa, lat, nrd, rm, ex);
        check("R9 older entries flushed", 64'(nrd), 64'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule